// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block sits on the device side of a chip-select-framed serial link and loads a 12-bit control word. While the active-low select is low, each falling edge of the serial clock samples one bit from the data line. A frame carries a 4-bit target code followed by 12 payload bits, and both are sent most significant bit first. The payload is written into the control word only when three conditions hold: the target code is 4'b0001, the serial configuration mode is enabled, and a 17th falling edge arrives after the 16 shifted bits.

The serial pins run far slower than the system clock, which samples them. Select, serial clock and data pass through matched synchronizer stages, and an edge detector on the synchronized serial clock yields one bit event per falling edge. The control word feeds four decoded outputs: a read-select code, a power-down mode, a gain code, and a calibration-start pulse. A one-cycle write strobe marks every commit so that downstream logic can latch the new settings.

Top module: `cfg_serial_ctl`

## Requirements
- R1: After reset the control word is all zero: rd_sel = 0, pd_mode = 0, gain = 0, and neither wr_strobe nor cal_start is asserted.
- R2: Bits are taken on falling serial clock edges, MSB first. The 16-bit frame is target[15:12] then payload[11:0]. The payload maps as rd_sel = [11:8], calibration = [7], pd_mode = [6:4], gain = [3:0].
- R3: Only the target code 4'b0001 updates the control word. Any other code leaves every output field unchanged and produces no wr_strobe.
- R4: A commit takes place only on the 17th falling edge of a frame. If select rises after 16 or fewer edges, the frame is discarded and the control word keeps its value.
- R5: Falling edges after the 17th in the same frame neither alter the control word nor cause a second commit.
- R6: While serial_en is low, frames are ignored: no field changes and no wr_strobe occurs.
- R7: Every commit produces exactly one wr_strobe pulse, one system clock long, in the cycle in which the new field values first appear.
- R8: cal_start pulses for one cycle together with wr_strobe when the committed payload bit [7] is 1. It never pulses otherwise.
- R9: Serial clock edges while select is high are ignored. Each new frame counts bits from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_en | input | 1 | 1 when serial configuration is enabled (external gain pins all zero) |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, MSB first |
| rd_sel | output | 4 | Read-select code from the control word |
| cal_start | output | 1 | One-cycle calibration start pulse |
| pd_mode | output | 3 | Power-down mode code |
| gain | output | 4 | Gain code |
| wr_strobe | output | 1 | One-cycle pulse on each commit |

## Verification
The write strobe and the calibration pulse are the two events that fall in the same system cycle. A frame whose payload has bit [7] set provokes them together, and the same frame with bit [7] clear provokes the strobe alone. Both are judged by counting pulses per frame with a cycle monitor. Any cycle that shows a calibration pulse without a strobe counts as a mismatch. The bench also sweeps every target code, every gain and power-down value, and edge counts on both sides of 17 to confirm that each frame produces exactly one commit or none.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 12;
  localparam int FRAME_W  = ADDR_W + DATA_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'b0001;

  typedef struct packed {
    logic [3:0] rd_sel;
    logic       cal;
    logic [2:0] pd;
    logic [3:0] gain;
  } ctrl_t;

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1 -: ADDR_W];
  endfunction

  function automatic ctrl_t frame_payload(input logic [FRAME_W-1:0] f);
    return ctrl_t'(f[DATA_W-1:0]);
  endfunction
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_frame_shift.sv
module cfg_frame_shift #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n_s,
  input  logic               sclk_s,
  input  logic               sdi_s,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               bit_evt,
  output logic               last_evt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;

  // falling edge of the synchronized serial clock inside a frame
  assign bit_evt  = sclk_q & ~sclk_s & ~sel_n_s;
  assign last_evt = bit_evt && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      frame   <= '0;
    end else if (sel_n_s) begin
      bit_cnt <= '0;
    end else if (bit_evt && bit_cnt <= LAST) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt < LAST) frame <= {frame[FRAME_W-2:0], sdi_s};
    end
endmodule

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
  import cfg_serial_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  commit,
  input  ctrl_t next_word,
  output ctrl_t word,
  output logic  wr_strobe,
  output logic  cal_start
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word      <= '0;
      wr_strobe <= 1'b0;
      cal_start <= 1'b0;
    end else begin
      wr_strobe <= commit;
      cal_start <= commit & next_word.cal;
      if (commit) word <= next_word;
    end
endmodule

// File: rtl/cfg_serial_ctl.sv
module cfg_serial_ctl
  import cfg_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_en,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic [3:0] rd_sel,
  output logic       cal_start,
  output logic [2:0] pd_mode,
  output logic [3:0] gain,
  output logic       wr_strobe
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bit_cnt;
  logic               bit_evt;
  logic               last_evt;
  logic               commit;
  ctrl_t              word;

  // order: {select, serial clock, data}; select idles high
  cfg_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({cs_n, sclk, sdi}), .q(pins_s)
  );

  cfg_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .frame(frame), .bit_cnt(bit_cnt), .bit_evt(bit_evt), .last_evt(last_evt)
  );

  assign commit = last_evt & serial_en & (frame_addr(frame) == CTRL_ADDR);

  cfg_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .commit(commit), .next_word(frame_payload(frame)),
    .word(word), .wr_strobe(wr_strobe), .cal_start(cal_start)
  );

  assign rd_sel  = word.rd_sel;
  assign pd_mode = word.pd;
  assign gain    = word.gain;

  logic unused_cal;
  assign unused_cal = word.cal;
endmodule

// File: rtl/cfg_serial_ctl_chk.sv
module cfg_serial_ctl_chk #(
  parameter int CW      = 5,
  parameter int FRAME_W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          serial_en,
  input logic          wr_strobe,
  input logic          cal_start,
  input logic [10:0]   fields,
  input logic [CW-1:0] bit_cnt,
  input logic          bit_evt
);
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  p_cal_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> wr_strobe);

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> $stable(fields));

  p_mode_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_en |=> !wr_strobe);

  p_commit_on_17th_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($past(bit_cnt) == CW'(FRAME_W)) && $past(bit_evt));
endmodule

bind cfg_serial_ctl cfg_serial_ctl_chk #(.CW(CNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .serial_en(serial_en), .wr_strobe(wr_strobe),
  .cal_start(cal_start), .fields({rd_sel, pd_mode, gain}),
  .bit_cnt(bit_cnt), .bit_evt(bit_evt)
);

// File: tb/cfg_serial_ctl_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_ctl_tb_top;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serial_en = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [3:0] rd_sel;
  logic       cal_start;
  logic [2:0] pd_mode;
  logic [3:0] gain;
  logic       wr_strobe;

  always #2 clk = ~clk;

  cfg_serial_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .serial_en(serial_en), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .rd_sel(rd_sel), .cal_start(cal_start),
    .pd_mode(pd_mode), .gain(gain), .wr_strobe(wr_strobe)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_strobe = 0;
  int n_cal = 0;
  int n_orphan = 0;
  bit done = 0;
  logic [11:0] exp_word = '0;

  always @(negedge clk) begin
    if (wr_strobe) n_strobe++;
    if (cal_start) n_cal++;
    if (cal_start && !wr_strobe) n_orphan++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int edges);
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < edges; i++) begin
      @(negedge clk);
      sdi = (i < 16) ? w[15 - i] : 1'b0;
      wait_clk(HALF);
      @(negedge clk) sclk = 1'b1;
      wait_clk(HALF);
      @(negedge clk) sclk = 1'b0;
      wait_clk(HALF);
    end
    @(negedge clk) cs_n = 1'b1;
    wait_clk(8);
  endtask

  // issue a frame and compare against the arithmetic model
  task automatic frame_chk(input string req, input logic [15:0] w, input int edges);
    bit hit;
    int s0, c0;
    hit = serial_en && (edges >= 17) && ((w >> 12) == 1);
    s0 = n_strobe; c0 = n_cal;
    send(w, edges);
    if (hit) exp_word = w % 4096;
    @(negedge clk);
    chk({req, " rd_sel"},  rd_sel,  (exp_word >> 8) % 16);
    chk({req, " pd_mode"}, pd_mode, (exp_word >> 4) % 8);
    chk({req, " gain"},    gain,    exp_word % 16);
    chk({req, " strobes R7"}, n_strobe - s0, hit ? 1 : 0);
    chk({req, " cal R8"}, n_cal - c0, (hit && ((w >> 7) % 2 == 1)) ? 1 : 0);
  endtask

  initial begin
    wait_clk(5);
    @(negedge clk);
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 gain", gain, 0);
    chk("R1 pd", pd_mode, 0);
    chk("R1 strobe", wr_strobe, 0);
    chk("R1 cal", cal_start, 0);
    rst_n = 1'b1;
    wait_clk(4);
    @(negedge clk);
    chk("R1 after release", {rd_sel, pd_mode, gain}, 0);
    chk("R1 no pulses", n_strobe + n_cal, 0);

    // R2 field sweep: every gain, every pd, varied rd_sel
    for (int g = 0; g < 16; g++)
      frame_chk("R2 gain", 16'h1000 + ((15 - g) << 8) + g, 17);
    for (int p = 0; p < 8; p++)
      frame_chk("R2 pd", 16'h1000 + (p << 4) + (p * 2 % 16), 17);
    // R8 calibration with and without the bit
    frame_chk("R8 cal set", 16'h1A95, 17);
    frame_chk("R8 cal clear", 16'h1A15, 17);
    // R3 every other target code
    for (int a = 0; a < 16; a++)
      if (a != 1) frame_chk("R3 other addr", (a << 12) + 12'hF3C, 17);
    // R4 short frames
    frame_chk("R4 15 edges", 16'h1FFF, 15);
    frame_chk("R4 16 edges", 16'h1FFF, 16);
    frame_chk("R4 17 edges", 16'h1C36, 17);
    // R5 extra edges
    frame_chk("R5 20 edges", 16'h14E9, 20);
    frame_chk("R5 18 edges", 16'h15F2, 18);
    // R6 serial mode disabled
    serial_en = 1'b0;
    frame_chk("R6 disabled", 16'h1FFF, 17);
    frame_chk("R6 disabled cal", 16'h1080, 17);
    serial_en = 1'b1;
    frame_chk("R6 re-enabled", 16'h12A7, 17);
    // R9 serial clock toggles while select is high
    begin
      int s0;
      s0 = n_strobe;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk) sdi = i[0];
        sclk = 1'b1; wait_clk(HALF);
        @(negedge clk) sclk = 1'b0; wait_clk(HALF);
      end
      wait_clk(6);
      @(negedge clk);
      chk("R9 idle clocks strobe", n_strobe - s0, 0);
      chk("R9 idle clocks fields", {rd_sel, pd_mode, gain}, exp_word[11:8] * 128 + exp_word[6:0]);
    end
    // R9 aborted frame followed by a full frame counts from zero
    frame_chk("R9 abort", 16'h1333, 9);
    frame_chk("R9 fresh frame", 16'h1B5A, 17);
    chk("R8 orphan cal pulses", n_orphan, 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule